// File: doc/BRIEF.md
# Nth-Chance Clock Victim Selector

This block chooses which physical page frame to give up when a new page must be brought in. It keeps a small record for every frame: a use flag, a dirty flag and a counter of how many sweeps have passed the frame while it sat unused. A clock hand points at one frame. The hand moves only while a replacement is being served. It does not move with time.

A reference port marks frames as they are touched. Any access sets the use flag, and a write also sets the dirty flag. A clean port lets the write-back path report that a frame is back in step with the disk. When an eviction request arrives, the hand looks at one frame per clock. A frame that was used recently is forgiven: its use flag and counter are cleared and the hand moves on. A frame that was not used has its counter advanced. A clean frame is given up on its first unused visit. A dirty frame gets one extra pass, and a write-back hint is raised on that first pass so the copy to disk can start early. The block then reports the chosen frame and whether it still needs a write-back. The hand comes to rest on the frame just past the victim.

Top module: `clock_sweep_victim`

## Requirements
- R1: After reset, busy, done and wb_start are low and every frame record is cleared. The first eviction request on a fresh table returns frame 0 with victim_wb low.
- R2: The request is sampled at a clock edge. The block then examines exactly one frame at each following edge, and done rises after the edge that examines the k-th frame. done is high for one cycle, and busy is high only from the request until that point.
- R3: The hand moves only while a request is being served. After done it rests on victim_idx + 1, wrapping to 0 after frame NUM_PAGES-1, even if many idle cycles pass before the next request.
- R4: A visited frame whose use flag is 1 has its use flag and counter cleared, and the hand passes it by.
- R5: A visited clean frame whose use flag is 0 is chosen as the victim at that visit (one chance), with victim_wb = 0.
- R6: A visited dirty frame whose use flag is 0 is chosen only on its second unused visit, with victim_wb = 1. The first such visit pulses wb_start for one cycle with wb_start_idx set to that frame.
- R7: When every use flag is set, the sweep clears them all, wraps around and still chooses the frame where it started (FIFO order).
- R8: ref_valid sets the use flag of ref_idx. A write (ref_write = 1) also sets the dirty flag, and a read does not. A reference to the frame under the hand in the same cycle that the hand visits it takes priority: that frame is treated as used.
- R9: clean_valid clears the dirty flag of clean_idx, so that frame is then chosen after a single unused visit, with victim_wb = 0.
- R10: evict_req is ignored while a sweep is in progress. It produces no second done and does not change the current result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A frame is being accessed this cycle |
| ref_idx | input | IDX_W | Frame being accessed |
| ref_write | input | 1 | The access is a write (sets the dirty flag) |
| clean_valid | input | 1 | The write-back of a frame has completed |
| clean_idx | input | IDX_W | Frame whose dirty flag is to be cleared |
| evict_req | input | 1 | Start a victim search (sampled only when idle) |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle pulse: the victim outputs are valid |
| victim_idx | output | IDX_W | Chosen frame, held until the next done |
| victim_wb | output | 1 | The chosen frame was dirty when it was chosen |
| wb_start | output | 1 | One-cycle hint to begin writing back a dirty frame |
| wb_start_idx | output | IDX_W | Frame named by wb_start |

## Verification
Every result of this block depends on how many frames the hand examines. done is due after the edge that examines the k-th frame, so k+1 edges after the edge that samples the request. Each scenario starts from reset, so k can be worked out from the frame records it sets up. The bench drives the request on a falling edge and counts falling edges until done appears, then compares that count with k+1. wb_start pulses fall between those edges, so a falling-edge monitor counts them and records the first index.

// File: rtl/clock_sweep_pkg.sv
package clock_sweep_pkg;

   // controller state
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SWEEP = 1'b1
   } sweep_state_t;

   // outcome of one hand visit, applied to the frame record under the hand
   typedef enum logic [1:0] {
      V_SKIP = 2'd0,   // recently used: clear use and counter
      V_AGE  = 2'd1,   // unused: counter + 1
      V_PICK = 2'd2    // unused and out of chances: becomes the victim
   } visit_kind_t;

endpackage

// File: rtl/frame_record_table.sv
module frame_record_table
   import clock_sweep_pkg::*;
#(
   parameter int NUM_PAGES = 8,
   parameter int IDX_W     = 3,
   parameter int CNT_W     = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ref_valid,
   input  logic [IDX_W-1:0]                ref_idx,
   input  logic                            ref_write,
   input  logic                            clean_valid,
   input  logic [IDX_W-1:0]                clean_idx,
   input  logic                            upd_valid,
   input  logic [IDX_W-1:0]                upd_idx,
   input  visit_kind_t                     upd_kind,
   output logic [NUM_PAGES-1:0]            use_vec,
   output logic [NUM_PAGES-1:0]            dirty_vec,
   output logic [NUM_PAGES-1:0][CNT_W-1:0] cnt_arr
);

   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_frame
      logic             hit_ref, hit_upd, hit_clean;
      logic             use_q, dirty_q;
      logic [CNT_W-1:0] cnt_q;

      assign hit_ref   = ref_valid   && (ref_idx   == IDX_W'(p));
      assign hit_upd   = upd_valid   && (upd_idx   == IDX_W'(p));
      assign hit_clean = clean_valid && (clean_idx == IDX_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            use_q   <= 1'b0;
            dirty_q <= 1'b0;
            cnt_q   <= '0;
         end else begin
            // a reference always wins over a sweep clear of the same frame
            if (hit_ref)
               use_q <= 1'b1;
            else if (hit_upd)
               use_q <= 1'b0;

            if (hit_ref && ref_write)
               dirty_q <= 1'b1;
            else if (hit_upd && upd_kind == V_PICK)
               dirty_q <= 1'b0;
            else if (hit_clean)
               dirty_q <= 1'b0;

            if (hit_upd) begin
               unique case (upd_kind)
                  V_AGE:   cnt_q <= cnt_q + CNT_W'(1);
                  default: cnt_q <= '0;
               endcase
            end
         end
      end

      assign use_vec[p]   = use_q;
      assign dirty_vec[p] = dirty_q;
      assign cnt_arr[p]   = cnt_q;
   end

endmodule

// File: rtl/sweep_hand_ctrl.sv
module sweep_hand_ctrl
   import clock_sweep_pkg::*;
#(
   parameter int NUM_PAGES     = 8,
   parameter int CLEAN_CHANCES = 1,
   parameter int DIRTY_CHANCES = 2,
   parameter int IDX_W         = 3,
   parameter int CNT_W         = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            evict_req,
   input  logic                            ref_valid,
   input  logic [IDX_W-1:0]                ref_idx,
   input  logic [NUM_PAGES-1:0]            use_vec,
   input  logic [NUM_PAGES-1:0]            dirty_vec,
   input  logic [NUM_PAGES-1:0][CNT_W-1:0] cnt_arr,
   output logic                            upd_valid,
   output logic [IDX_W-1:0]                upd_idx,
   output visit_kind_t                     upd_kind,
   output logic [IDX_W-1:0]                hand,
   output logic                            busy,
   output logic                            done,
   output logic [IDX_W-1:0]                victim_idx,
   output logic                            victim_wb,
   output logic                            wb_start,
   output logic [IDX_W-1:0]                wb_start_idx
);

   localparam logic [CNT_W-1:0] CLEAN_LIM = CNT_W'(CLEAN_CHANCES);
   localparam logic [CNT_W-1:0] DIRTY_LIM = CNT_W'(DIRTY_CHANCES);
   localparam logic [CNT_W-1:0] WB_MARK   = CNT_W'(1);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_PAGES - 1);

   sweep_state_t     state_q;
   logic [IDX_W-1:0] hand_q, hand_nxt;
   logic             use_sel, dirty_sel, ref_on_hand;
   logic [CNT_W-1:0] cnt_sel, cnt_inc, limit;
   visit_kind_t      verdict;

   always_comb begin
      use_sel     = use_vec[hand_q];
      dirty_sel   = dirty_vec[hand_q];
      cnt_sel     = cnt_arr[hand_q];
      ref_on_hand = ref_valid && (ref_idx == hand_q);
      cnt_inc     = cnt_sel + CNT_W'(1);
      limit       = dirty_sel ? DIRTY_LIM : CLEAN_LIM;
      if (use_sel || ref_on_hand)
         verdict = V_SKIP;
      else if (cnt_inc >= limit)
         verdict = V_PICK;
      else
         verdict = V_AGE;
   end

   // hand wrap: free for power-of-two tables, compared otherwise
   if ((NUM_PAGES & (NUM_PAGES - 1)) == 0) begin : g_wrap_pow2
      assign hand_nxt = hand_q + IDX_W'(1);
   end else begin : g_wrap_cmp
      assign hand_nxt = (hand_q == LAST_IDX) ? '0 : hand_q + IDX_W'(1);
   end

   assign upd_valid = (state_q == ST_SWEEP);
   assign upd_idx   = hand_q;
   assign upd_kind  = verdict;
   assign hand      = hand_q;
   assign busy      = (state_q == ST_SWEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         hand_q       <= '0;
         done         <= 1'b0;
         victim_idx   <= '0;
         victim_wb    <= 1'b0;
         wb_start     <= 1'b0;
         wb_start_idx <= '0;
      end else begin
         done     <= 1'b0;
         wb_start <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (evict_req)
                  state_q <= ST_SWEEP;
            end
            ST_SWEEP: begin
               hand_q <= hand_nxt;
               if (verdict == V_PICK) begin
                  state_q    <= ST_IDLE;
                  done       <= 1'b1;
                  victim_idx <= hand_q;
                  victim_wb  <= dirty_sel;
               end else if (verdict == V_AGE && dirty_sel && cnt_inc == WB_MARK) begin
                  wb_start     <= 1'b1;
                  wb_start_idx <= hand_q;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/clock_sweep_victim.sv
module clock_sweep_victim
   import clock_sweep_pkg::*;
#(
   parameter int NUM_PAGES     = 8,
   parameter int CLEAN_CHANCES = 1,
   parameter int DIRTY_CHANCES = 2,
   parameter int IDX_W         = $clog2(NUM_PAGES),
   parameter int CNT_W         = $clog2(DIRTY_CHANCES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_valid,
   input  logic [IDX_W-1:0] ref_idx,
   input  logic             ref_write,
   input  logic             clean_valid,
   input  logic [IDX_W-1:0] clean_idx,
   input  logic             evict_req,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] victim_idx,
   output logic             victim_wb,
   output logic             wb_start,
   output logic [IDX_W-1:0] wb_start_idx
);

   if (NUM_PAGES < 2) begin : g_bad_pages
      $error("NUM_PAGES must be at least 2");
   end
   if (CLEAN_CHANCES < 1 || DIRTY_CHANCES < CLEAN_CHANCES) begin : g_bad_chances
      $error("need 1 <= CLEAN_CHANCES <= DIRTY_CHANCES");
   end
   if (IDX_W < $clog2(NUM_PAGES) || CNT_W < $clog2(DIRTY_CHANCES + 1)) begin : g_bad_widths
      $error("index or counter width too small");
   end

   logic [NUM_PAGES-1:0]            use_vec, dirty_vec;
   logic [NUM_PAGES-1:0][CNT_W-1:0] cnt_arr;
   logic                            upd_valid;
   logic [IDX_W-1:0]                upd_idx;
   visit_kind_t                     upd_kind;
   logic [IDX_W-1:0]                hand_w;

   frame_record_table #(
      .NUM_PAGES (NUM_PAGES),
      .IDX_W     (IDX_W),
      .CNT_W     (CNT_W)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_valid   (ref_valid),
      .ref_idx     (ref_idx),
      .ref_write   (ref_write),
      .clean_valid (clean_valid),
      .clean_idx   (clean_idx),
      .upd_valid   (upd_valid),
      .upd_idx     (upd_idx),
      .upd_kind    (upd_kind),
      .use_vec     (use_vec),
      .dirty_vec   (dirty_vec),
      .cnt_arr     (cnt_arr)
   );

   sweep_hand_ctrl #(
      .NUM_PAGES     (NUM_PAGES),
      .CLEAN_CHANCES (CLEAN_CHANCES),
      .DIRTY_CHANCES (DIRTY_CHANCES),
      .IDX_W         (IDX_W),
      .CNT_W         (CNT_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .evict_req    (evict_req),
      .ref_valid    (ref_valid),
      .ref_idx      (ref_idx),
      .use_vec      (use_vec),
      .dirty_vec    (dirty_vec),
      .cnt_arr      (cnt_arr),
      .upd_valid    (upd_valid),
      .upd_idx      (upd_idx),
      .upd_kind     (upd_kind),
      .hand         (hand_w),
      .busy         (busy),
      .done         (done),
      .victim_idx   (victim_idx),
      .victim_wb    (victim_wb),
      .wb_start     (wb_start),
      .wb_start_idx (wb_start_idx)
   );

endmodule

// File: rtl/clock_sweep_checker.sv
module clock_sweep_checker #(
   parameter int NUM_PAGES     = 8,
   parameter int DIRTY_CHANCES = 2,
   parameter int IDX_W         = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             evict_req,
   input logic             busy,
   input logic             done,
   input logic [IDX_W-1:0] victim_idx,
   input logic             wb_start,
   input logic [IDX_W-1:0] hand
);

   logic [IDX_W-1:0] rest_pos;
   always_comb
      rest_pos = (victim_idx == IDX_W'(NUM_PAGES - 1)) ? '0 : victim_idx + IDX_W'(1);

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R3
   hand_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (hand == rest_pos));

   // R3
   hand_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !evict_req) |=> $stable(hand));

   // R6
   wb_before_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (DIRTY_CHANCES > 1 && wb_start) |-> (!done && $past(busy)));

endmodule

bind clock_sweep_victim clock_sweep_checker #(
   .NUM_PAGES     (NUM_PAGES),
   .DIRTY_CHANCES (DIRTY_CHANCES),
   .IDX_W         (IDX_W)
) u_sweep_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evict_req  (evict_req),
   .busy       (busy),
   .done       (done),
   .victim_idx (victim_idx),
   .wb_start   (wb_start),
   .hand       (hand_w)
);

// File: tb/test_clock_sweep_victim.sv
module test_clock_sweep_victim;

   localparam int NP = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_valid = 1'b0;
   logic [IW-1:0] ref_idx = '0;
   logic          ref_write = 1'b0;
   logic          clean_valid = 1'b0;
   logic [IW-1:0] clean_idx = '0;
   logic          evict_req = 1'b0;
   logic          busy, done, victim_wb, wb_start;
   logic [IW-1:0] victim_idx, wb_start_idx;

   int checks = 0;
   int fails  = 0;
   int wb_seen = 0;
   int wb_first = -1;

   always #10 clk = ~clk;   // 50 MHz

   clock_sweep_victim #(.NUM_PAGES(NP)) i_clock_sweep_victim (
      .clk          (clk),
      .rst_n        (rst_n),
      .ref_valid    (ref_valid),
      .ref_idx      (ref_idx),
      .ref_write    (ref_write),
      .clean_valid  (clean_valid),
      .clean_idx    (clean_idx),
      .evict_req    (evict_req),
      .busy         (busy),
      .done         (done),
      .victim_idx   (victim_idx),
      .victim_wb    (victim_wb),
      .wb_start     (wb_start),
      .wb_start_idx (wb_start_idx)
   );

   always @(negedge clk) begin
      if (rst_n && wb_start) begin
         if (wb_seen == 0) wb_first = int'(wb_start_idx);
         wb_seen++;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ref_valid = 1'b0; clean_valid = 1'b0; evict_req = 1'b0; ref_write = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      wb_seen = 0;
      wb_first = -1;
   endtask

   task automatic touch(input int idx, input bit wr);
      @(negedge clk);
      ref_valid = 1'b1; ref_idx = IW'(idx); ref_write = wr;
      @(negedge clk);
      ref_valid = 1'b0; ref_write = 1'b0;
   endtask

   // request, then count edges from the sampling edge until done is seen
   task automatic fire(output int n);
      @(negedge clk);
      evict_req = 1'b1;
      @(negedge clk);
      evict_req = 1'b0;
      n = 1;
      while (!done && n < 100) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset_state();
      int n;
      do_reset();
      check(!busy, "R1 busy after reset", int'(busy), 0);
      check(!done && !wb_start, "R1 done/wb_start after reset", int'(done), 0);
      fire(n);
      check(n == 2, "R1 R2 latency fresh table", n, 2);
      check(victim_idx == 0, "R1 R5 fresh victim", int'(victim_idx), 0);
      check(!victim_wb, "R1 fresh victim_wb", int'(victim_wb), 0);
   endtask

   task automatic t_hand_resume();
      int n;
      do_reset();
      fire(n);
      @(negedge clk);
      check(!done, "R2 done one cycle", int'(done), 0);
      repeat (10) @(negedge clk);
      fire(n);
      check(victim_idx == 1 && n == 2, "R3 resume past victim", int'(victim_idx), 1);
   endtask

   task automatic t_use_skip();
      int n;
      do_reset();
      touch(0, 1'b0);
      fire(n);
      check(n == 3, "R4 R2 latency with one skip", n, 3);
      check(victim_idx == 1 && !victim_wb, "R4 used frame passed", int'(victim_idx), 1);
   endtask

   task automatic t_fifo_wrap();
      int n;
      do_reset();
      for (int i = 0; i < NP; i++) touch(i, 1'b0);
      @(negedge clk);
      evict_req = 1'b1;
      @(negedge clk);
      evict_req = 1'b0;
      n = 1;
      check(busy, "R2 busy during sweep", int'(busy), 1);
      while (!done && n < 100) begin
         if (n == 4) evict_req = 1'b1;   // extra request mid-sweep
         else        evict_req = 1'b0;
         @(negedge clk);
         n++;
      end
      evict_req = 1'b0;
      check(n == NP + 2, "R7 R2 latency full wrap", n, NP + 2);
      check(victim_idx == 0, "R7 FIFO victim", int'(victim_idx), 0);
      check(!victim_wb, "R8 read leaves frame clean", int'(victim_wb), 0);
      begin
         int extra = 0;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (done || busy) extra++;
         end
         check(extra == 0, "R10 busy request ignored", extra, 0);
      end
   endtask

   task automatic t_dirty_two_pass();
      int n;
      do_reset();
      for (int i = 0; i < NP; i++) touch(i, 1'b1);
      fire(n);
      check(n == 2 * NP + 2, "R6 R8 latency dirty table", n, 2 * NP + 2);
      check(victim_idx == 0, "R6 dirty victim", int'(victim_idx), 0);
      check(victim_wb, "R6 victim_wb", int'(victim_wb), 1);
      check(wb_seen == NP, "R6 wb_start count", wb_seen, NP);
      check(wb_first == 0, "R6 first wb_start_idx", wb_first, 0);
   endtask

   task automatic t_clean_port();
      int n;
      do_reset();
      for (int i = 0; i < NP; i++) touch(i, 1'b1);
      @(negedge clk);
      clean_valid = 1'b1; clean_idx = '0;
      @(negedge clk);
      clean_valid = 1'b0;
      fire(n);
      check(n == NP + 2, "R9 latency after clean", n, NP + 2);
      check(victim_idx == 0 && !victim_wb, "R9 cleaned victim_wb", int'(victim_wb), 0);
      check(wb_seen == 0, "R9 no wb hint", wb_seen, 0);
   endtask

   task automatic t_ref_priority();
      int n;
      do_reset();
      @(negedge clk);
      evict_req = 1'b1;
      @(negedge clk);
      evict_req = 1'b0;
      ref_valid = 1'b1; ref_idx = '0; ref_write = 1'b0;   // hits frame under hand
      @(negedge clk);
      ref_valid = 1'b0;
      n = 2;
      while (!done && n < 100) begin
         @(negedge clk);
         n++;
      end
      check(n == 3, "R8 latency with colliding ref", n, 3);
      check(victim_idx == 1, "R8 reference wins over sweep", int'(victim_idx), 1);
   endtask

   initial begin
      #(20 * 200000);
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      t_reset_state();
      t_hand_resume();
      t_use_skip();
      t_fifo_wrap();
      t_dirty_two_pass();
      t_clean_port();
      t_ref_priority();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule